// File: doc/BRIEF.md
# Exception Entry Unit

This block applies, in a single clock edge, the architectural state changes a processor makes when it takes an exception. It holds the 64-bit machine state word and two save/restore registers. A one-cycle take pulse arrives with a 12-bit vector offset, the address of the instruction in flight, a program-exception reason code, and four per-exception masks: a clear mask and a set mask for the new state, and another pair for the saved state. On that edge it saves the return address and a filtered copy of the old state, rewrites the state word and presents the address of the handler to fetch next.

The standard vector offsets are 0x200 machine check, 0x300 data storage, 0x400 instruction storage, 0x500 external, 0x600 alignment, 0x700 program, 0x800 floating-point unavailable, 0x900 decrementer, 0xC00 system call and 0xE00 floating-point assist. Two of these change the entry sequence itself: the system-call offset moves the return address past the calling instruction, and the program offset lets the reason code mark the cause in the saved state. An exception taken while the recoverable bit of the old state is clear raises a sticky double-exception flag, and the entry sequence still completes.

Bit indices below count from 0 at the least significant bit.

Top module: `exc_entry_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets state_o to 64'h2, which has only the recoverable bit (bit 1) set, and sets save0_o, save1_o, next_pc_o and dbl_exc_o to zero.
- R2: At a clock edge where take_i is low, state_o, save0_o, save1_o and next_pc_o keep their values, whatever the other inputs hold.
- R3: At a clock edge where take_i is high, state_o becomes the old state with bits 1, 4, 5, 8, 9, 10, 11, 13, 14, 15 and 18 cleared and bit 63 (wide mode) set, then ANDed with the inverse of st_clr_i, then ORed with st_set_i.
- R4: At a take edge save0_o becomes cia_i, except that when vec_off_i is 12'hC00 it becomes cia_i + 4.
- R5: At a take edge save1_o becomes the old state ANDed with a keep mask of bits 63:31, 26:22 and 15:0, then ANDed with the inverse of sv_clr_i, then ORed with sv_set_i and the reason bit of R6.
- R6: When vec_off_i is 12'h700 at a take edge, prog_why_i selects one reason bit in save1_o: code 1 sets bit 20 (floating-point enabled), code 2 or 3 sets bit 19 (illegal or unsupported optional instruction), code 4 sets bit 18 (privileged), code 5 sets bit 17 (trap); codes 0, 6 and 7 set none. For any other vector offset prog_why_i has no effect.
- R7: At a take edge next_pc_o becomes vec_off_i plus a base, where the base is 64'hFFFF_FFFF_FFF0_0000 (bits 63:20 all ones) if bit 6 (vector prefix) of the new state from R3 is set, and zero otherwise.
- R8: At a take edge where bit 1 of the old state is clear, dbl_exc_o becomes 1 and stays 1 until reset; the registers of R3 to R7 still update on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| take_i | input | 1 | One-cycle pulse: take an exception at this edge |
| vec_off_i | input | 12 | Vector offset of the exception |
| cia_i | input | 64 | Address of the instruction in flight |
| prog_why_i | input | 3 | Program-exception reason code |
| st_clr_i | input | 64 | Bits to clear in the new state |
| st_set_i | input | 64 | Bits to set in the new state |
| sv_clr_i | input | 64 | Bits to clear in the saved state |
| sv_set_i | input | 64 | Bits to set in the saved state |
| state_o | output | 64 | Machine state word |
| save0_o | output | 64 | First save/restore register (return address) |
| save1_o | output | 64 | Second save/restore register (saved state) |
| next_pc_o | output | 64 | Handler fetch address |
| dbl_exc_o | output | 1 | Sticky double-exception flag |

## Verification
The assertions take for granted that take_i is a clean synchronous level sampled at each edge and that the mask inputs are stable around that edge; the reason-field check assumes sv_set_i does not itself drive bits 20:17 when the offset is not the program vector, and the low-bit vector check assumes the base never overlaps the offset field. The stimulus keeps to this by driving every input on the falling edge, confining sv_set_i values outside the program vector to bits that miss the reason field, and using the default base width. Back-to-back take pulses, idle stretches with every mask input at all ones, and a reset in the middle of the run exercise the registers against an independent scoreboard model.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

   localparam int STATE_BITS = 64;

   // state word bit indices, counted from the least significant bit
   localparam int B_WIDE  = 63;
   localparam int B_POWER = 18;
   localparam int B_EXTEN = 15;
   localparam int B_USER  = 14;
   localparam int B_FPAV  = 13;
   localparam int B_FEM0  = 11;
   localparam int B_STEP  = 10;
   localparam int B_BRTR  = 9;
   localparam int B_FEM1  = 8;
   localparam int B_VPFX  = 6;
   localparam int B_IREL  = 5;
   localparam int B_DREL  = 4;
   localparam int B_RECOV = 1;

   // reason field of the saved state
   localparam int R_FPEN  = 20;
   localparam int R_ILL   = 19;
   localparam int R_PRIV  = 18;
   localparam int R_TRAP  = 17;

   localparam logic [11:0] OFF_SYSCALL = 12'hC00;
   localparam logic [11:0] OFF_PROGRAM = 12'h700;

   typedef enum logic [2:0] {
      WHY_NONE = 3'd0,
      WHY_FPEN = 3'd1,
      WHY_ILL  = 3'd2,
      WHY_OPT  = 3'd3,
      WHY_PRIV = 3'd4,
      WHY_TRAP = 3'd5
   } why_e;

   // bits that are always dropped when an exception is entered
   function automatic logic [STATE_BITS-1:0] entry_zap_mask();
      logic [STATE_BITS-1:0] m;
      m = '0;
      m[B_POWER] = 1'b1;
      m[B_EXTEN] = 1'b1;
      m[B_USER]  = 1'b1;
      m[B_FPAV]  = 1'b1;
      m[B_FEM0]  = 1'b1;
      m[B_STEP]  = 1'b1;
      m[B_BRTR]  = 1'b1;
      m[B_FEM1]  = 1'b1;
      m[B_IREL]  = 1'b1;
      m[B_DREL]  = 1'b1;
      m[B_RECOV] = 1'b1;
      return m;
   endfunction

   // bits of the old state copied into the saved state; ranges are given
   // in most-significant-first numbering and converted here
   function automatic logic [STATE_BITS-1:0] save_keep_mask();
      logic [STATE_BITS-1:0] m;
      m = '0;
      for (int k = 0; k < STATE_BITS; k++) begin
         int msb_idx;
         msb_idx = STATE_BITS - 1 - k;
         if (msb_idx <= 32 || (msb_idx >= 37 && msb_idx <= 41) || msb_idx >= 48)
            m[k] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [STATE_BITS-1:0] reason_field_mask();
      logic [STATE_BITS-1:0] m;
      m = '0;
      m[R_FPEN] = 1'b1;
      m[R_ILL]  = 1'b1;
      m[R_PRIV] = 1'b1;
      m[R_TRAP] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/exc_state_build.sv
`timescale 1ns/1ps
module exc_state_build
   import exc_entry_pkg::*;
#(
   parameter int ST_W = 64
)(
   input  logic [ST_W-1:0] old_i,
   input  logic [ST_W-1:0] clr_i,
   input  logic [ST_W-1:0] set_i,
   output logic [ST_W-1:0] new_o
);
   localparam logic [ST_W-1:0] ZAP  = ST_W'(entry_zap_mask());
   localparam logic [ST_W-1:0] WIDE = ST_W'(1) << B_WIDE;

   logic [ST_W-1:0] forced;

   always_comb begin
      forced = (old_i & ~ZAP) | WIDE;
      new_o  = (forced & ~clr_i) | set_i;
   end
endmodule

// File: rtl/exc_save_build.sv
`timescale 1ns/1ps
module exc_save_build
   import exc_entry_pkg::*;
#(
   parameter int ST_W  = 64,
   parameter int VEC_W = 12
)(
   input  logic [ST_W-1:0]  old_i,
   input  logic [ST_W-1:0]  clr_i,
   input  logic [ST_W-1:0]  set_i,
   input  logic [VEC_W-1:0] vec_i,
   input  logic [2:0]       why_i,
   output logic [ST_W-1:0]  save_o
);
   localparam logic [ST_W-1:0]  KEEP   = ST_W'(save_keep_mask());
   localparam logic [VEC_W-1:0] PROG_V = VEC_W'(OFF_PROGRAM);

   logic [ST_W-1:0] why_bits;
   logic            is_prog;

   always_comb begin
      is_prog  = (vec_i == PROG_V);
      why_bits = '0;
      if (is_prog) begin
         unique case (why_e'(why_i))
            WHY_FPEN:          why_bits[R_FPEN] = 1'b1;
            WHY_ILL, WHY_OPT:  why_bits[R_ILL]  = 1'b1;
            WHY_PRIV:          why_bits[R_PRIV] = 1'b1;
            WHY_TRAP:          why_bits[R_TRAP] = 1'b1;
            default:           why_bits = '0;
         endcase
      end
      save_o = (old_i & KEEP & ~clr_i) | set_i | why_bits;
   end
endmodule

// File: rtl/exc_vector_gen.sv
`timescale 1ns/1ps
module exc_vector_gen
   import exc_entry_pkg::*;
#(
   parameter int PC_W      = 64,
   parameter int VEC_W     = 12,
   parameter int BASE_ONES = 44,
   parameter int RET_STEP  = 4,
   parameter bit USE_ADDER = 1'b0
)(
   input  logic             prefix_i,
   input  logic [VEC_W-1:0] vec_i,
   input  logic [PC_W-1:0]  cia_i,
   output logic [PC_W-1:0]  next_pc_o,
   output logic [PC_W-1:0]  ret_o
);
   localparam int              LOW_W  = PC_W - BASE_ONES;
   localparam logic [PC_W-1:0] HI_BASE = {{BASE_ONES{1'b1}}, {LOW_W{1'b0}}};
   localparam logic [VEC_W-1:0] SC_V  = VEC_W'(OFF_SYSCALL);

   logic [PC_W-1:0] base;
   logic [PC_W-1:0] off_ext;

   assign base    = prefix_i ? HI_BASE : '0;
   assign off_ext = PC_W'(vec_i);

   generate
      if (USE_ADDER) begin : g_add
         assign next_pc_o = base + off_ext;
      end else begin : g_or
         // offset field lies below the base ones, so OR equals add
         assign next_pc_o = base | off_ext;
      end
   endgenerate

   assign ret_o = (vec_i == SC_V) ? cia_i + PC_W'(RET_STEP) : cia_i;
endmodule

// File: rtl/exc_entry_unit.sv
`timescale 1ns/1ps
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int              ST_W        = 64,
   parameter int              PC_W        = 64,
   parameter int              VEC_W       = 12,
   parameter int              BASE_ONES   = 44,
   parameter int              RET_STEP    = 4,
   parameter bit              USE_ADDER   = 1'b0,
   parameter logic [ST_W-1:0] RESET_STATE = ST_W'(2)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             take_i,
   input  logic [VEC_W-1:0] vec_off_i,
   input  logic [PC_W-1:0]  cia_i,
   input  logic [2:0]       prog_why_i,
   input  logic [ST_W-1:0]  st_clr_i,
   input  logic [ST_W-1:0]  st_set_i,
   input  logic [ST_W-1:0]  sv_clr_i,
   input  logic [ST_W-1:0]  sv_set_i,
   output logic [ST_W-1:0]  state_o,
   output logic [PC_W-1:0]  save0_o,
   output logic [ST_W-1:0]  save1_o,
   output logic [PC_W-1:0]  next_pc_o,
   output logic             dbl_exc_o
);
   localparam logic [ST_W-1:0]  WHY_FIELD = ST_W'(reason_field_mask());
   localparam logic [VEC_W-1:0] PROG_V    = VEC_W'(OFF_PROGRAM);
   localparam logic [VEC_W-1:0] SC_V      = VEC_W'(OFF_SYSCALL);

   generate
      if (ST_W != STATE_BITS) begin : g_bad_state_w
         $error("exc_entry_unit: ST_W must equal the fixed state layout width");
      end
      if (VEC_W < 12) begin : g_bad_vec_w
         $error("exc_entry_unit: VEC_W must hold the 12-bit vector offsets");
      end
      if (!USE_ADDER && (BASE_ONES + VEC_W > PC_W)) begin : g_bad_base
         $error("exc_entry_unit: OR merge needs base ones clear of the offset field");
      end
   endgenerate

   logic [ST_W-1:0] st_q, sv1_q, st_nxt, sv1_nxt;
   logic [PC_W-1:0] sv0_q, pc_q, pc_nxt, ret_nxt;
   logic            dbl_q;

   exc_state_build #(.ST_W(ST_W)) state_i (
      .old_i (st_q),
      .clr_i (st_clr_i),
      .set_i (st_set_i),
      .new_o (st_nxt)
   );

   exc_save_build #(.ST_W(ST_W), .VEC_W(VEC_W)) save_i (
      .old_i  (st_q),
      .clr_i  (sv_clr_i),
      .set_i  (sv_set_i),
      .vec_i  (vec_off_i),
      .why_i  (prog_why_i),
      .save_o (sv1_nxt)
   );

   exc_vector_gen #(
      .PC_W(PC_W), .VEC_W(VEC_W), .BASE_ONES(BASE_ONES),
      .RET_STEP(RET_STEP), .USE_ADDER(USE_ADDER)
   ) vector_i (
      .prefix_i  (st_nxt[B_VPFX]),
      .vec_i     (vec_off_i),
      .cia_i     (cia_i),
      .next_pc_o (pc_nxt),
      .ret_o     (ret_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= RESET_STATE;
         sv0_q <= '0;
         sv1_q <= '0;
         pc_q  <= '0;
         dbl_q <= 1'b0;
      end else if (take_i) begin
         st_q  <= st_nxt;
         sv0_q <= ret_nxt;
         sv1_q <= sv1_nxt;
         pc_q  <= pc_nxt;
         if (!st_q[B_RECOV]) dbl_q <= 1'b1;
      end
   end

   assign state_o   = st_q;
   assign save0_o   = sv0_q;
   assign save1_o   = sv1_q;
   assign next_pc_o = pc_q;
   assign dbl_exc_o = dbl_q;

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !take_i |=> $stable(state_o) && $stable(save0_o) && $stable(save1_o) && $stable(next_pc_o));

   assert_recov_drop_R3: assert property (@(posedge clk) disable iff (rst)
      take_i && !st_set_i[B_RECOV] |=> !state_o[B_RECOV]);

   assert_wide_set_R3: assert property (@(posedge clk) disable iff (rst)
      take_i && !st_clr_i[B_WIDE] |=> state_o[B_WIDE]);

   assert_ret_addr_R4: assert property (@(posedge clk) disable iff (rst)
      take_i && (vec_off_i != SC_V) |=> save0_o == $past(cia_i));

   assert_save_set_R5: assert property (@(posedge clk) disable iff (rst)
      take_i |=> (save1_o & $past(sv_set_i)) == $past(sv_set_i));

   assert_no_reason_R6: assert property (@(posedge clk) disable iff (rst)
      take_i && (vec_off_i != PROG_V) && ((sv_set_i & WHY_FIELD) == '0)
      |=> (save1_o & WHY_FIELD) == '0);

   assert_reason_single_R6: assert property (@(posedge clk) disable iff (rst)
      take_i && (vec_off_i == PROG_V) && ((sv_set_i & WHY_FIELD) == '0)
      |=> $onehot0(save1_o & WHY_FIELD));

   assert_vec_low_R7: assert property (@(posedge clk) disable iff (rst)
      take_i |=> next_pc_o[VEC_W-1:0] == $past(vec_off_i));

   assert_dbl_raise_R8: assert property (@(posedge clk) disable iff (rst)
      take_i && !state_o[B_RECOV] |=> dbl_exc_o);

   assert_dbl_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      dbl_exc_o |=> dbl_exc_o);

endmodule

// File: tb/exc_entry_unit_tb_top.sv
`timescale 1ns/1ps
module exc_entry_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        take_i;
   logic [11:0] vec_off_i;
   logic [63:0] cia_i;
   logic [2:0]  prog_why_i;
   logic [63:0] st_clr_i, st_set_i, sv_clr_i, sv_set_i;
   logic [63:0] state_o, save0_o, save1_o, next_pc_o;
   logic        dbl_exc_o;

   always #10 clk = ~clk;

   exc_entry_unit dut_i (
      .clk(clk), .rst(rst), .take_i(take_i), .vec_off_i(vec_off_i),
      .cia_i(cia_i), .prog_why_i(prog_why_i),
      .st_clr_i(st_clr_i), .st_set_i(st_set_i),
      .sv_clr_i(sv_clr_i), .sv_set_i(sv_set_i),
      .state_o(state_o), .save0_o(save0_o), .save1_o(save1_o),
      .next_pc_o(next_pc_o), .dbl_exc_o(dbl_exc_o)
   );

   // constants written from the requirements
   localparam logic [63:0] ZAP_BITS = (64'd1 << 1) | (64'd1 << 4) | (64'd1 << 5) |
      (64'd1 << 8) | (64'd1 << 9) | (64'd1 << 10) | (64'd1 << 11) | (64'd1 << 13) |
      (64'd1 << 14) | (64'd1 << 15) | (64'd1 << 18);
   localparam logic [63:0] WIDE_BIT = 64'd1 << 63;
   localparam logic [63:0] KEEP_BITS = {33'h1_FFFF_FFFF, 4'h0, 5'h1F, 6'h00, 16'hFFFF};
   localparam logic [63:0] HI_BASE  = 64'hFFFF_FFFF_FFF0_0000;
   localparam logic [63:0] RECOV    = 64'd1 << 1;
   localparam logic [63:0] VPFX     = 64'd1 << 6;

   typedef struct packed {
      logic [63:0] st;
      logic [63:0] s0;
      logic [63:0] s1;
      logic [63:0] pc;
      logic        dbl;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   exp_t  cur;
   string cur_tag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [63:0] m_st, m_s0, m_s1, m_pc;
   logic        m_dbl;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: compares each expected item one step after its clock edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() != 0) begin
            cur     = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            chk({cur_tag, "/R3"}, "state", state_o, cur.st);
            chk({cur_tag, "/R4"}, "save0", save0_o, cur.s0);
            chk({cur_tag, "/R5"}, "save1", save1_o, cur.s1);
            chk({cur_tag, "/R7"}, "next_pc", next_pc_o, cur.pc);
            chk({cur_tag, "/R8"}, "dbl", {63'd0, dbl_exc_o}, {63'd0, cur.dbl});
         end
      end
   end

   task automatic push_model(input string tag);
      exp_t e;
      e.st = m_st; e.s0 = m_s0; e.s1 = m_s1; e.pc = m_pc; e.dbl = m_dbl;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // driver: one take pulse, expected result pushed to the scoreboard
   task automatic fire(input logic [11:0] v, input logic [63:0] cia,
                       input logic [2:0] why, input logic [63:0] sc,
                       input logic [63:0] ss, input logic [63:0] vc,
                       input logic [63:0] vs, input string tag);
      logic [63:0] old, nst, rb;
      @(negedge clk);
      take_i = 1'b1; vec_off_i = v; cia_i = cia; prog_why_i = why;
      st_clr_i = sc; st_set_i = ss; sv_clr_i = vc; sv_set_i = vs;
      old = m_st;
      nst = (((old & ~ZAP_BITS) | WIDE_BIT) & ~sc) | ss;
      rb  = 64'd0;
      if (v == 12'h700) begin
         case (why)
            3'd1:       rb = 64'd1 << 20;
            3'd2, 3'd3: rb = 64'd1 << 19;
            3'd4:       rb = 64'd1 << 18;
            3'd5:       rb = 64'd1 << 17;
            default:    rb = 64'd0;
         endcase
      end
      m_s1  = (old & KEEP_BITS & ~vc) | vs | rb;
      m_s0  = (v == 12'hC00) ? cia + 64'd4 : cia;
      m_pc  = (nst[6] ? HI_BASE : 64'd0) + {52'd0, v};
      m_dbl = m_dbl | ~old[1];
      m_st  = nst;
      push_model(tag);
   endtask

   // idle cycles with busy-looking inputs that must be ignored (R2)
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         take_i = 1'b0; vec_off_i = 12'h700; cia_i = 64'hDEAD_BEEF_0BAD_F00D;
         prog_why_i = 3'd5;
         st_clr_i = '1; st_set_i = '1; sv_clr_i = '1; sv_set_i = '1;
         push_model("R2");
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; take_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "state", state_o, 64'h2);
      chk("R1", "save0", save0_o, 64'd0);
      chk("R1", "save1", save1_o, 64'd0);
      chk("R1", "next_pc", next_pc_o, 64'd0);
      chk("R1", "dbl", {63'd0, dbl_exc_o}, 64'd0);
      rst = 1'b0;
      m_st = 64'h2; m_s0 = '0; m_s1 = '0; m_pc = '0; m_dbl = 1'b0;
   endtask

   initial begin
      rst = 1'b1; take_i = 1'b0; vec_off_i = '0; cia_i = '0; prog_why_i = '0;
      st_clr_i = '0; st_set_i = '0; sv_clr_i = '0; sv_set_i = '0;
      do_reset();

      // plain entry: recoverable bit dropped, wide mode forced (R3, R5, R7)
      fire(12'h200, 64'h0000_0000_0000_1000, 3'd0, '0, '0, '0, '0, "R3");
      idle(3);
      // rich old state via set mask, prefix on, recoverable kept
      fire(12'h300, 64'h0000_0040_0000_2000, 3'd0, '0,
           64'h5A5A_0F0F_F0F0_FFC2, '0, 64'h0000_0000_0100_0000, "R5");
      // save mask clear and high-base vector (R7)
      fire(12'h400, 64'h0000_0040_0000_2004, 3'd0, 64'h0000_00FF_0000_0000,
           RECOV | VPFX, 64'hFFFF_0000_0000_00F0, '0, "R7");
      // system call: return address moves by four (R4)
      fire(12'hC00, 64'h2000_0000_1234_5670, 3'd0, VPFX, RECOV, '0, '0, "R4");
      fire(12'hC00, 64'hFFFF_FFFF_FFFF_FFFC, 3'd0, '0, RECOV | VPFX, '0, '0, "R4");
      // program reasons, every code (R6)
      for (int w = 0; w < 8; w++)
         fire(12'h700, 64'h0000_0000_0000_3000 + 64'(w), 3'(w), '0, RECOV, '0, '0, "R6");
      // reason code ignored on other vectors (R6)
      fire(12'h600, 64'h0000_0000_0000_4000, 3'd5, '0, RECOV, '0, '0, "R6");
      fire(12'h500, 64'h0000_0000_0000_4004, 3'd1, '0, RECOV | VPFX, '0, '0, "R6");
      // clear mask removes forced wide bit (R3)
      fire(12'h800, 64'h0000_0000_0000_5000, 3'd0, WIDE_BIT, RECOV, '0, '0, "R3");
      fire(12'h900, 64'h0000_0000_0000_5004, 3'd0, '0, RECOV, '0, '0, "R7");
      idle(2);
      // recoverable lost, then a second entry raises the flag (R8)
      fire(12'hE00, 64'h0000_0000_0000_6000, 3'd0, '0, '0, '0, '0, "R8");
      fire(12'h200, 64'h0000_0000_0000_6004, 3'd0, '0, RECOV, '0, '0, "R8");
      fire(12'h300, 64'h0000_0000_0000_6008, 3'd0, '0, RECOV, '0, '0, "R8");
      idle(2);
      // flag held through idle, cleared by reset (R1)
      @(posedge clk);
      #3;
      do_reset();
      fire(12'h500, 64'h0000_0000_0000_7000, 3'd0, '0, '0, '0, '0, "R8");
      idle(2);
      @(posedge clk);
      #5;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule